// File: doc/BRIEF.md
# Compact 16-bit-Instruction Processor Core

This block is a single-issue processor core with 16-bit instructions and a 64-entry file of 32-bit registers. It holds its own 1024-word instruction store and a 10-bit program counter. Each instruction reads two register operands. The first is the destination field (5 bits, so only registers 0 to 31 can be written by ALU results). The second is the source field (6 bits, so any of the 64 registers can be read). Most instructions finish in one active cycle. Memory instructions take two: in the first the core issues a request to an external data-memory unit, and in the second it retires the instruction and writes any load result.

A host loads code and data into the core before starting it. It has write strobes for a register, the program counter and an instruction word. Writing the program counter also clears the halt flag. The host then raises `run_i` and waits until `halted_o` rises, which happens when a wait instruction executes. The instruction counter and the cycle counter let the host measure how long a program ran.

Top module: `mini16_core`

## Requirements
- R1: After reset, `pc_o` is 0, `halted_o` is 0, `barrier_o` and both counters are 0, and `mem_req_o` is low.
- R2: Opcodes 0x0 to 0xA in bits 15:11 compute a value from the destination register (bits 10:6) and the source register (bits 5:0) and write it to the destination register. The operations, in opcode order, are: add, subtract, shift left, arithmetic shift right, logical shift right, and, or, nor, signed less-than, unsigned less-than and move. Register 0 always reads as zero, even after an instruction writes it.
- R3: The three shifts move the destination value by source[4:0] places, and the arithmetic right shift fills with the sign bit.
- R4: The two less-than operations write 1 when the comparison holds and 0 otherwise. The signed one treats both operands as two's complement; the unsigned one does not.
- R5: Opcodes 0x10, 0x11, 0x12 and 0x13 branch when the destination register is, respectively, zero, nonzero, non-negative (bit 31 clear) or negative. A taken branch moves the PC to PC plus the sign-extended bits 5:0, modulo 1024. An untaken branch moves the PC to PC+1.
- R6: Opcodes 0x16 and 0x17 set the PC to the source register's low 10 bits and write the old PC+1 into the destination register. When both fields name the same register, the jump target is that register's old value.
- R7: Opcodes 0x18 (word) and 0x19 (byte) load from the byte address held in the source register. The request is a single `mem_req_o` pulse, and `mem_rdata_i` is taken in the cycle after it. A byte load returns lane address[1:0] of the word (lane 0 is bits 7:0), zero-extended.
- R8: Opcodes 0x1A (word) and 0x1B (byte) store the source register to the byte address held in the destination register. A word store drives `mem_be_o`=4'hF. A byte store drives a one-hot `mem_be_o` that selects lane address[1:0], and copies the low byte into all four data lanes.
- R9: Opcode 0x1C loads the word at the zero-extended byte address in bits 10:0 into register 1.
- R10: Opcode 0xC is an escape that makes bits 15:6 the opcode. The value 10'b0110000000 is wait: it sets `halted_o`, leaves the PC on the wait instruction and counts as retired. The core stays halted with the PC held until the host writes the PC.
- R11: The escaped opcode 10'b0110010000 copies the source register into `barrier_o`.
- R12: Any other opcode, including escaped values other than the two above, changes no register and advances the PC by 1.
- R13: `inst_count_o` rises by 1 for each retired instruction. `cycle_count_o` rises by 1 for each active cycle, so a memory instruction costs two cycles and any other instruction one. Neither counter moves while the core is idle or halted.
- R14: Host writes to a register, the PC or instruction memory take effect at the next edge. While any host strobe is high, the core starts no instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Allows execution while high |
| host_reg_we_i | input | 1 | Host register write strobe |
| host_reg_addr_i | input | 6 | Host register index |
| host_reg_data_i | input | 32 | Host register data |
| host_pc_we_i | input | 1 | Host PC write strobe; also clears halt |
| host_pc_i | input | 10 | Host PC value |
| host_imem_we_i | input | 1 | Host instruction write strobe |
| host_imem_addr_i | input | 10 | Host instruction word address |
| host_imem_data_i | input | 16 | Host instruction word |
| mem_req_o | output | 1 | Data memory request, one cycle |
| mem_we_o | output | 1 | Request is a store |
| mem_be_o | output | 4 | Byte enables of a store |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 32 | Store data |
| mem_rdata_i | input | 32 | Load data, valid the cycle after a load request |
| pc_o | output | 10 | Program counter |
| halted_o | output | 1 | Core halted by wait |
| barrier_o | output | 32 | Barrier register |
| inst_count_o | output | 32 | Retired instruction count |
| cycle_count_o | output | 32 | Active cycle count |

## Verification
The hardest state to reach from the ports is a core stopped in the middle of execution by host traffic. The bench parks the core on a branch that targets itself, with `run_i` high, and then holds a host register strobe for several cycles. During those cycles both counters and the PC must stay frozen, and they must resume one step per cycle once the strobe drops. Register contents are never visible at the ports, so every register result is read by running a two-instruction store-then-wait routine. The bench then inspects its own memory model. A second hard case is a jump whose destination and target fields name the same register.

// File: rtl/mini16_pkg.sv
package mini16_pkg;
  localparam int unsigned ILEN   = 16;
  localparam int unsigned REG_AW = 6;
  localparam logic [4:0] OP_ESC  = 5'h0C;
  localparam logic [9:0] OP_WAIT = 10'b0110000000;
  localparam logic [9:0] OP_BAR  = 10'b0110010000;

  typedef enum logic [3:0] {
    C_NOP, C_ALU, C_BR, C_JMP, C_LD, C_ST, C_GLD, C_WAIT, C_BAR
  } cls_e;

  typedef enum logic [3:0] {
    A_ADD, A_SUB, A_SLL, A_SRA, A_SRL, A_AND, A_OR, A_NOR, A_SLT, A_SLTU, A_MOV
  } alu_e;

  typedef enum logic [1:0] {B_ZERO, B_NZ, B_POS, B_NEG} cond_e;

  typedef struct packed {
    cls_e              cls;
    alu_e              alu;
    cond_e             cond;
    logic              byte_op;
    logic [REG_AW-1:0] rd;
    logic [REG_AW-1:0] rs;
    logic [10:0]       imm11;
    logic [5:0]        imm6;
  } dec_t;
endpackage

// File: rtl/mini16_decode.sv
module mini16_decode
  import mini16_pkg::*;
(
  input  logic [ILEN-1:0] instr_i,
  output dec_t            dec_o
);
  logic [4:0] op5;
  assign op5 = instr_i[15:11];

  always_comb begin
    dec_o         = '0;
    dec_o.rd      = {1'b0, instr_i[10:6]};
    dec_o.rs      = instr_i[5:0];
    dec_o.imm11   = instr_i[10:0];
    dec_o.imm6    = instr_i[5:0];
    dec_o.cls     = C_NOP;
    dec_o.alu     = A_ADD;
    dec_o.cond    = cond_e'(op5[1:0]);
    dec_o.byte_op = op5[0];
    if (op5 <= 5'h0A) begin
      dec_o.cls = C_ALU;
      dec_o.alu = alu_e'(op5[3:0]);
    end else if (op5 == OP_ESC) begin
      if (instr_i[15:6] == OP_WAIT)      dec_o.cls = C_WAIT;
      else if (instr_i[15:6] == OP_BAR)  dec_o.cls = C_BAR;
    end else begin
      unique case (op5)
        5'h10, 5'h11, 5'h12, 5'h13: dec_o.cls = C_BR;
        5'h16, 5'h17:               dec_o.cls = C_JMP;
        5'h18, 5'h19:               dec_o.cls = C_LD;
        5'h1A, 5'h1B:               dec_o.cls = C_ST;
        5'h1C:                      dec_o.cls = C_GLD;
        default:                    dec_o.cls = C_NOP;
      endcase
    end
  end
endmodule

// File: rtl/mini16_alu.sv
module mini16_alu
  import mini16_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  alu_e            op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] y_o
);
  localparam int unsigned SH_W = $clog2(XLEN);
  logic [SH_W-1:0] sh;
  assign sh = b_i[SH_W-1:0];

  always_comb begin
    unique case (op_i)
      A_ADD:   y_o = a_i + b_i;
      A_SUB:   y_o = a_i - b_i;
      A_SLL:   y_o = a_i << sh;
      A_SRA:   y_o = XLEN'($signed(a_i) >>> sh);
      A_SRL:   y_o = a_i >> sh;
      A_AND:   y_o = a_i & b_i;
      A_OR:    y_o = a_i | b_i;
      A_NOR:   y_o = ~(a_i | b_i);
      A_SLT:   y_o = XLEN'($signed(a_i) < $signed(b_i));
      A_SLTU:  y_o = XLEN'(a_i < b_i);
      A_MOV:   y_o = b_i;
      default: y_o = a_i;
    endcase
  end
endmodule

// File: rtl/mini16_regfile.sv
module mini16_regfile #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned AW   = 6
) (
  input  logic            clk_i,
  input  logic [AW-1:0]   ra0_i,
  input  logic [AW-1:0]   ra1_i,
  output logic [XLEN-1:0] rd0_o,
  output logic [XLEN-1:0] rd1_o,
  input  logic            we_i,
  input  logic [AW-1:0]   wa_i,
  input  logic [XLEN-1:0] wd_i
);
  localparam int unsigned N = 1 << AW;
  logic [XLEN-1:0] regs [N];

  always_ff @(posedge clk_i)
    if (we_i) regs[wa_i] <= wd_i;

  // entry 0 is storage but never visible
  assign rd0_o = (ra0_i == '0) ? '0 : regs[ra0_i];
  assign rd1_o = (ra1_i == '0) ? '0 : regs[ra1_i];
endmodule

// File: rtl/mini16_imem.sv
module mini16_imem #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i)
    if (we_i) mem[waddr_i] <= wdata_i;

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/mini16_core.sv
module mini16_core
  import mini16_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned PC_W  = 10,
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              host_reg_we_i,
  input  logic [REG_AW-1:0] host_reg_addr_i,
  input  logic [XLEN-1:0]   host_reg_data_i,
  input  logic              host_pc_we_i,
  input  logic [PC_W-1:0]   host_pc_i,
  input  logic              host_imem_we_i,
  input  logic [PC_W-1:0]   host_imem_addr_i,
  input  logic [ILEN-1:0]   host_imem_data_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [XLEN/8-1:0] mem_be_o,
  output logic [XLEN-1:0]   mem_addr_o,
  output logic [XLEN-1:0]   mem_wdata_o,
  input  logic [XLEN-1:0]   mem_rdata_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              halted_o,
  output logic [XLEN-1:0]   barrier_o,
  output logic [CNT_W-1:0]  inst_count_o,
  output logic [CNT_W-1:0]  cycle_count_o
);
  localparam int unsigned NBYTE = XLEN / 8;
  localparam int unsigned LN_W  = $clog2(NBYTE);

  logic [PC_W-1:0]   pc_q, pc_plus1, br_tgt;
  logic              halted_q, mem_busy_q, ld_pend_q, ld_byte_q;
  logic [LN_W-1:0]   ld_lane_q;
  logic [REG_AW-1:0] ld_dst_q;
  logic [XLEN-1:0]   barrier_q;
  logic [CNT_W-1:0]  inst_q, cyc_q;

  logic [ILEN-1:0]   instr;
  dec_t              dec;
  logic [XLEN-1:0]   rd_val, rs_val, alu_y, ld_byte_val;
  logic              host_any, exec_go, br_take, is_mem;

  logic              c_we, rf_we;
  logic [REG_AW-1:0] c_wa, rf_wa;
  logic [XLEN-1:0]   c_wd, rf_wd;

  mini16_imem #(.AW(PC_W), .DW(ILEN)) u_imem (
    .clk_i   (clk_i),
    .we_i    (host_imem_we_i),
    .waddr_i (host_imem_addr_i),
    .wdata_i (host_imem_data_i),
    .raddr_i (pc_q),
    .rdata_o (instr)
  );

  mini16_decode u_dec (.instr_i(instr), .dec_o(dec));

  mini16_regfile #(.XLEN(XLEN), .AW(REG_AW)) u_rf (
    .clk_i (clk_i),
    .ra0_i (dec.rd),
    .ra1_i (dec.rs),
    .rd0_o (rd_val),
    .rd1_o (rs_val),
    .we_i  (rf_we),
    .wa_i  (rf_wa),
    .wd_i  (rf_wd)
  );

  mini16_alu #(.XLEN(XLEN)) u_alu (
    .op_i (dec.alu),
    .a_i  (rd_val),
    .b_i  (rs_val),
    .y_o  (alu_y)
  );

  assign host_any = host_reg_we_i | host_pc_we_i | host_imem_we_i;
  assign exec_go  = run_i & ~halted_q & ~mem_busy_q & ~host_any;
  assign pc_plus1 = pc_q + 1'b1;
  assign br_tgt   = pc_q + {{(PC_W-6){dec.imm6[5]}}, dec.imm6};
  assign is_mem   = (dec.cls == C_LD) || (dec.cls == C_ST) || (dec.cls == C_GLD);

  always_comb begin
    unique case (dec.cond)
      B_ZERO:  br_take = (rd_val == '0);
      B_NZ:    br_take = (rd_val != '0);
      B_POS:   br_take = ~rd_val[XLEN-1];
      default: br_take = rd_val[XLEN-1];
    endcase
  end

  // data memory request, issued in the first cycle of a memory instruction
  assign mem_req_o = exec_go & is_mem;
  assign mem_we_o  = (dec.cls == C_ST);
  always_comb begin
    unique case (dec.cls)
      C_ST:    mem_addr_o = rd_val;
      C_LD:    mem_addr_o = rs_val;
      default: mem_addr_o = {{(XLEN-11){1'b0}}, dec.imm11};
    endcase
    if (mem_we_o && dec.byte_op) begin
      mem_be_o    = NBYTE'(1) << mem_addr_o[LN_W-1:0];
      mem_wdata_o = {NBYTE{rs_val[7:0]}};
    end else begin
      mem_be_o    = '1;
      mem_wdata_o = rs_val;
    end
  end

  assign ld_byte_val = {{(XLEN-8){1'b0}}, 8'(mem_rdata_i >> {ld_lane_q, 3'b000})};

  always_comb begin
    c_we = 1'b0;
    c_wa = dec.rd;
    c_wd = alu_y;
    if (mem_busy_q) begin
      c_we = ld_pend_q;
      c_wa = ld_dst_q;
      c_wd = ld_byte_q ? ld_byte_val : mem_rdata_i;
    end else if (exec_go) begin
      if (dec.cls == C_ALU) c_we = 1'b1;
      if (dec.cls == C_JMP) begin
        c_we = 1'b1;
        c_wd = {{(XLEN-PC_W){1'b0}}, pc_plus1};
      end
    end
  end

  assign rf_we = host_reg_we_i | c_we;
  assign rf_wa = host_reg_we_i ? host_reg_addr_i : c_wa;
  assign rf_wd = host_reg_we_i ? host_reg_data_i : c_wd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q       <= '0;
      halted_q   <= 1'b0;
      mem_busy_q <= 1'b0;
      ld_pend_q  <= 1'b0;
      ld_byte_q  <= 1'b0;
      ld_lane_q  <= '0;
      ld_dst_q   <= '0;
      barrier_q  <= '0;
      inst_q     <= '0;
      cyc_q      <= '0;
    end else begin
      if (exec_go || mem_busy_q) cyc_q <= cyc_q + 1'b1;
      if (mem_busy_q) begin
        mem_busy_q <= 1'b0;
        pc_q       <= pc_plus1;
        inst_q     <= inst_q + 1'b1;
      end else if (exec_go) begin
        unique case (dec.cls)
          C_BR: begin
            pc_q   <= br_take ? br_tgt : pc_plus1;
            inst_q <= inst_q + 1'b1;
          end
          C_JMP: begin
            pc_q   <= rs_val[PC_W-1:0];
            inst_q <= inst_q + 1'b1;
          end
          C_LD, C_ST, C_GLD: begin
            mem_busy_q <= 1'b1;
            ld_pend_q  <= (dec.cls != C_ST);
            ld_byte_q  <= (dec.cls == C_LD) && dec.byte_op;
            ld_lane_q  <= mem_addr_o[LN_W-1:0];
            ld_dst_q   <= (dec.cls == C_GLD) ? REG_AW'(1) : dec.rd;
          end
          C_WAIT: begin
            halted_q <= 1'b1;
            inst_q   <= inst_q + 1'b1;
          end
          C_BAR: begin
            barrier_q <= rs_val;
            pc_q      <= pc_plus1;
            inst_q    <= inst_q + 1'b1;
          end
          default: begin
            pc_q   <= pc_plus1;
            inst_q <= inst_q + 1'b1;
          end
        endcase
      end
      if (host_pc_we_i) begin
        pc_q     <= host_pc_i;
        halted_q <= 1'b0;
      end
    end
  end

  assign pc_o          = pc_q;
  assign halted_o      = halted_q;
  assign barrier_o     = barrier_q;
  assign inst_count_o  = inst_q;
  assign cycle_count_o = cyc_q;
endmodule

// File: rtl/mini16_core_chk.sv
module mini16_core_chk #(
  parameter int unsigned PC_W  = 10,
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             host_reg_we_i,
  input logic             host_pc_we_i,
  input logic             host_imem_we_i,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [3:0]       mem_be_o,
  input logic [PC_W-1:0]  pc_o,
  input logic             halted_o,
  input logic [CNT_W-1:0] inst_count_o,
  input logic [CNT_W-1:0] cycle_count_o,
  input logic             mem_busy_q
);
  // R7
  mem_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> (!mem_req_o && mem_busy_q));

  // R8
  store_be_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_be_o == 4'hF || $countones(mem_be_o) == 1));

  // R10
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && !host_pc_we_i) |=> (halted_o && $stable(pc_o)));

  // R13
  inst_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_busy_q |=> (inst_count_o == $past(inst_count_o) || inst_count_o == $past(inst_count_o) + 1'b1));

  // R13
  idle_cycles_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !mem_busy_q) |=> $stable(cycle_count_o));

  // R14
  host_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((host_reg_we_i || host_imem_we_i || host_pc_we_i) && !mem_busy_q)
      |=> ($stable(inst_count_o) && $stable(cycle_count_o)));
endmodule

bind mini16_core mini16_core_chk #(.PC_W(PC_W), .CNT_W(CNT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .run_i          (run_i),
  .host_reg_we_i  (host_reg_we_i),
  .host_pc_we_i   (host_pc_we_i),
  .host_imem_we_i (host_imem_we_i),
  .mem_req_o      (mem_req_o),
  .mem_we_o       (mem_we_o),
  .mem_be_o       (mem_be_o),
  .pc_o           (pc_o),
  .halted_o       (halted_o),
  .inst_count_o   (inst_count_o),
  .cycle_count_o  (cycle_count_o),
  .mem_busy_q     (mem_busy_q)
);

// File: tb/mini16_core_bench.sv
module mini16_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        h_reg_we = 1'b0, h_pc_we = 1'b0, h_im_we = 1'b0;
  logic [5:0]  h_reg_a = '0;
  logic [31:0] h_reg_d = '0;
  logic [9:0]  h_pc = '0, h_im_a = '0;
  logic [15:0] h_im_d = '0;
  logic        mem_req, mem_we, halted;
  logic [3:0]  mem_be;
  logic [31:0] mem_addr, mem_wdata, barrier, inst_cnt, cyc_cnt;
  logic [31:0] mem_rdata = '0;
  logic [9:0]  pc;
  logic [31:0] dmem [256];

  int errors = 0, checks = 0;
  bit done = 0;

  localparam logic [15:0] WAIT_I = 16'h6000;

  always #4 clk = ~clk;

  mini16_core u_mini16_core (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run),
    .host_reg_we_i(h_reg_we), .host_reg_addr_i(h_reg_a), .host_reg_data_i(h_reg_d),
    .host_pc_we_i(h_pc_we), .host_pc_i(h_pc),
    .host_imem_we_i(h_im_we), .host_imem_addr_i(h_im_a), .host_imem_data_i(h_im_d),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_be_o(mem_be), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .pc_o(pc), .halted_o(halted), .barrier_o(barrier),
    .inst_count_o(inst_cnt), .cycle_count_o(cyc_cnt)
  );

  // data memory model: registered read, byte-enabled write
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) dmem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= dmem[mem_addr[9:2]];
      end
    end
  end

  function automatic logic [15:0] enc(int op, int rd, int rs);
    return {op[4:0], rd[4:0], rs[5:0]};
  endfunction

  function automatic logic [31:0] model(int op, logic [31:0] a, logic [31:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a << b[4:0];
      3: return $unsigned($signed(a) >>> b[4:0]);
      4: return a >> b[4:0];
      5: return a & b;
      6: return a | b;
      7: return ~(a | b);
      8: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      9: return (a < b) ? 32'd1 : 32'd0;
      default: return b;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_reg(int r, logic [31:0] v);
    @(negedge clk); h_reg_we = 1; h_reg_a = r[5:0]; h_reg_d = v;
    @(negedge clk); h_reg_we = 0;
  endtask

  task automatic set_im(int a, logic [15:0] d);
    @(negedge clk); h_im_we = 1; h_im_a = a[9:0]; h_im_d = d;
    @(negedge clk); h_im_we = 0;
  endtask

  task automatic set_pc(int p);
    @(negedge clk); h_pc_we = 1; h_pc = p[9:0];
    @(negedge clk); h_pc_we = 0;
  endtask

  task automatic run_prog(int start);
    set_pc(start);
    run = 1;
    for (int i = 0; i < 2000 && !halted; i++) @(negedge clk);
    run = 0;
  endtask

  // reads a register by storing it to word 252 (byte 0x3F0) through r30
  task automatic peek(int r, output logic [31:0] v);
    set_reg(30, 32'h3F0);
    set_im(1020, enc(5'h1A, 30, r));
    set_im(1021, WAIT_I);
    run_prog(1020);
    v = dmem[252];
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 pc", 32'(pc), 0);
    check("R1 halted", 32'(halted), 0);
    check("R1 inst", inst_cnt, 0);
    check("R1 cycles", cyc_cnt, 0);
    check("R1 req", 32'(mem_req), 0);
    check("R1 barrier", barrier, 0);
  endtask

  task automatic t_alu(logic [31:0] a, logic [31:0] b);
    logic [31:0] v, i0, c0;
    set_reg(1, a); set_reg(2, b);
    for (int k = 0; k < 11; k++) begin
      set_im(2*k, enc(5'h0A, 10+k, 1));
      set_im(2*k+1, enc(k, 10+k, 2));
    end
    set_im(22, enc(5'h0A, 0, 1));
    set_im(23, WAIT_I);
    set_pc(0);
    i0 = inst_cnt; c0 = cyc_cnt;
    run_prog(0);
    check("R13 alu insts", inst_cnt - i0, 24);
    check("R13 alu cycles", cyc_cnt - c0, 24);
    check("R10 pc on wait", 32'(pc), 23);
    for (int k = 0; k < 11; k++) begin
      peek(10+k, v);
      if (k >= 2 && k <= 4) check("R3 shift", v, model(k, a, b));
      else if (k == 8 || k == 9) check("R4 less-than", v, model(k, a, b));
      else check("R2 alu", v, model(k, a, b));
    end
    peek(0, v);
    check("R2 r0 zero", v, 0);
  endtask

  task automatic br_case(int op, logic [31:0] val, bit taken);
    set_reg(5, val);
    set_im(100, enc(op, 5, 5));
    set_im(105, WAIT_I);
    set_im(101, WAIT_I);
    run_prog(100);
    check("R5 branch", 32'(pc), taken ? 105 : 101);
  endtask

  task automatic t_branch;
    br_case(5'h10, 0, 1);
    br_case(5'h10, 1, 0);
    br_case(5'h11, 0, 0);
    br_case(5'h11, 7, 1);
    br_case(5'h12, 0, 1);
    br_case(5'h12, 32'h8000_0000, 0);
    br_case(5'h13, 32'hFFFF_FFFF, 1);
    br_case(5'h13, 5, 0);
    set_im(100, enc(5'h10, 0, 6'h3D));
    set_im(97, WAIT_I);
    run_prog(100);
    check("R5 backward", 32'(pc), 97);
    set_im(2, enc(5'h10, 0, 6'h3C));
    set_im(1022, WAIT_I);
    run_prog(2);
    check("R5 wrap", 32'(pc), 1022);
  endtask

  task automatic t_jump;
    logic [31:0] v;
    set_reg(7, 200);
    set_im(50, enc(5'h16, 8, 7));
    set_im(200, WAIT_I);
    run_prog(50);
    check("R6 target", 32'(pc), 200);
    peek(8, v);
    check("R6 link", v, 51);
    set_reg(9, 300);
    set_im(60, enc(5'h17, 9, 9));
    set_im(300, WAIT_I);
    run_prog(60);
    check("R6 same reg target", 32'(pc), 300);
    peek(9, v);
    check("R6 same reg link", v, 61);
  endtask

  task automatic t_mem;
    logic [31:0] v, i0, c0;
    dmem[4] = 32'hA1B2_C3D4;
    dmem[9] = 32'h1122_3344;
    dmem[8] = 32'h0;
    set_reg(2, 32'h12); set_reg(10, 32'h10); set_reg(5, 32'h20);
    set_reg(6, 32'h25); set_reg(7, 32'h1234_5699); set_reg(11, 32'h13);
    set_im(0, enc(5'h19, 3, 2));
    set_im(1, enc(5'h18, 4, 10));
    set_im(2, enc(5'h1A, 5, 4));
    set_im(3, enc(5'h1B, 6, 7));
    set_im(4, {5'h1C, 11'h010});
    set_im(5, enc(5'h19, 12, 11));
    set_im(6, WAIT_I);
    set_pc(0);
    i0 = inst_cnt; c0 = cyc_cnt;
    run_prog(0);
    check("R13 mem insts", inst_cnt - i0, 7);
    check("R13 mem cycles", cyc_cnt - c0, 13);
    check("R8 word store", dmem[8], 32'hA1B2_C3D4);
    check("R8 byte store", dmem[9], 32'h1122_9944);
    peek(3, v);  check("R7 byte load lane2", v, 32'hB2);
    peek(12, v); check("R7 byte load lane3", v, 32'hA1);
    peek(4, v);  check("R7 word load", v, 32'hA1B2_C3D4);
    peek(1, v);  check("R9 global load", v, 32'hA1B2_C3D4);
  endtask

  task automatic t_wait_bar;
    logic [31:0] i0;
    set_reg(5, 32'hCAFE_0001);
    set_im(400, {10'b0110010000, 6'd5});
    set_im(401, WAIT_I);
    run_prog(400);
    check("R11 barrier", barrier, 32'hCAFE_0001);
    check("R10 halted", 32'(halted), 1);
    i0 = inst_cnt;
    run = 1;
    repeat (5) @(negedge clk);
    run = 0;
    check("R10 pc held", 32'(pc), 401);
    check("R10 no retire when halted", inst_cnt, i0);
    set_pc(10);
    check("R10 host pc clears halt", 32'(halted), 0);
  endtask

  task automatic t_invalid;
    logic [31:0] v, i0;
    set_reg(11, 32'h55);
    set_im(500, enc(5'h0B, 11, 2));
    set_im(501, enc(5'h1F, 11, 2));
    set_im(502, {10'b0110000001, 6'd2});
    set_im(503, enc(5'h0D, 11, 2));
    set_im(504, WAIT_I);
    set_pc(500);
    i0 = inst_cnt;
    run_prog(500);
    check("R12 pc", 32'(pc), 504);
    check("R12 retired", inst_cnt - i0, 5);
    peek(11, v);
    check("R12 reg untouched", v, 32'h55);
  endtask

  task automatic t_host;
    logic [31:0] c, v;
    set_im(600, enc(5'h10, 0, 0));
    set_pc(600);
    run = 1;
    repeat (3) @(negedge clk);
    c = inst_cnt;
    h_reg_we = 1; h_reg_a = 6'd12; h_reg_d = 32'h0BAD_F00D;
    repeat (3) @(negedge clk);
    check("R14 frozen insts", inst_cnt, c);
    check("R14 frozen pc", 32'(pc), 600);
    h_reg_we = 0;
    repeat (2) @(negedge clk);
    check("R14 resumes", inst_cnt, c + 2);
    run = 0;
    peek(12, v);
    check("R14 host reg write", v, 32'h0BAD_F00D);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_alu(32'h8000_0005, 32'h3);
    t_alu(32'h7, 32'hFFFF_FFF0);
    t_branch();
    t_jump();
    t_mem();
    t_wait_bar();
    t_invalid();
    t_host();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule